// File: doc/BRIEF.md
# Comparator Output Conditioner

This block sits behind the one-bit result of an analog comparator and cleans it up in the digital domain. The raw bit is first brought into the block clock domain through a two-flop synchronizer. It is then optionally inverted and optionally held in one more register stage. After that it passes through a glitch filter whose behaviour and window length, counted in clock cycles, are programmable. The conditioned level is driven out on `cond_out`. Rising and falling transitions of that level are captured in two sticky flags, and each flag can be routed to an interrupt line and to a DMA request line, each under its own enable bit.

Software uses a simple word-wide write port and a registered read port to program the block and to clear the flags. Several control fields (comparator enable, fast mode, pin output enable, reference enable, input selects, hysteresis, window mode and the 8-bit reference level) drive analog circuitry outside this block. Here they are only stored and read back.

Register addresses: 0 control word, 1 reference level (8 bits), 2 edge flags, 3 interrupt enables, 4 DMA enables. Any other address reads as zero. Control word bit positions: [11:0] filter window length, [14:12] filter mode, 15 extra output stage, 16 invert, 17 filter bypass, 18 window mode, 19 comparator enable, 20 fast mode, 21 pin output enable, 22 reference enable, [25:23] positive select, [28:26] negative select, [30:29] hysteresis.

Top module: `cmpc_conditioner`

## Requirements
- R1: After a synchronous reset, `cond_out`, `irq` and `dma_req` are 0 and every register reads 0.
- R2: The raw input always passes through two synchronizer flops. When control bit 15 is 0, a level applied before clock edge k reaches `cond_out` after edge k+2 in bypass. When bit 15 is 1, one more stage is added and the level arrives after edge k+3.
- R3: When control bit 16 is 1, the comparator level is inverted before the filter. When it is 0, the level passes unchanged.
- R4: Filter mode code 000, the reserved codes 001 to 011, and control bit 17 set (under any mode code) all pass the level straight through the filter's single output register.
- R5: Mode 100 (change immediately): a new level is taken on the next edge. After that the output holds for at least the window length in cycles and ignores the input, then it follows the input again.
- R6: Mode 101 (change after filter): the output takes a new level only after the filter input has differed from the output for a full window of consecutive cycles. A shorter excursion leaves the output unchanged.
- R7: Mode 110 drives `cond_out` to constant 0, and mode 111 drives it to constant 1, whatever the input.
- R8: With a window length of 0, modes 100 and 101 behave as pass-through, with the same latency as bypass.
- R9: Flag bit 0 sets on a rising edge of `cond_out` and flag bit 1 on a falling edge, both in the same cycle that `cond_out` changes. Flags are sticky and are cleared by writing 1 to the bit. A hardware set and a clear in the same cycle leave the flag set.
- R10: `irq` is the OR of each flag ANDed with its interrupt-enable bit (bit 0 for rising, bit 1 for falling). `dma_req` is formed the same way from the DMA-enable bits.
- R11: Stored-only fields (control bits 18 to 30 and the 8-bit reference level) read back as written, with bits above the level width dropped, and have no effect on `cond_out`. Unmapped addresses read 0.
- R12: `rd_data` shows the register addressed by `rd_addr` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_raw | input | 1 | Unsynchronized comparator result |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 31 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 31 | Registered read data |
| cond_out | output | 1 | Conditioned comparator level |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
In bypass, a level driven on `cmp_raw` is due on `cond_out` three edges later without the extra stage and four edges later with it. The edge flags and the request lines change in the same cycle as `cond_out`, and read data appears one edge after its address. The bench drives inputs on falling edges and keeps a behavioural model that advances on every rising edge from the same sampled inputs. It compares `cond_out`, `irq` and `dma_req` with the model at every falling edge. Directed checks then sample at the exact edge counts for the latency, lockout and window cases, so an output that arrives one cycle early or late is caught.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;
  typedef enum logic [2:0] {
    FM_PASS  = 3'b000,
    FM_IMMED = 3'b100,
    FM_AFTER = 3'b101,
    FM_LOW   = 3'b110,
    FM_HIGH  = 3'b111
  } filt_mode_e;

  localparam int A_CTRL  = 0;
  localparam int A_LEVEL = 1;
  localparam int A_FLAGS = 2;
  localparam int A_IRQEN = 3;
  localparam int A_DMAEN = 4;

  // Reserved codes and the bypass bit collapse to pass-through.
  function automatic filt_mode_e decode_mode(input logic [2:0] code, input logic byp);
    if (byp) return FM_PASS;
    case (code)
      3'b100, 3'b101, 3'b110, 3'b111: return filt_mode_e'(code);
      default: return FM_PASS;
    endcase
  endfunction
endpackage

// File: rtl/cmpc_front.sv
module cmpc_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic invert,
  input  logic stage_en,
  output logic sel
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   stage_q;
  logic                   pol;

  assign pol = chain_q[SYNC_STAGES-1] ^ invert;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      stage_q <= 1'b0;
    end else begin
      chain_q[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) chain_q[i] <= chain_q[i-1];
      stage_q <= pol;
    end
  end

  assign sel = stage_en ? stage_q : pol;
endmodule

// File: rtl/cmpc_filter.sv
module cmpc_filter
  import cmpc_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  filt_mode_e       mode,
  input  logic [LEN_W-1:0] len,
  output logic             out_q,
  output logic             rise,
  output logic             fall
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             nxt;

  always_comb begin
    nxt   = out_q;
    cnt_d = '0;
    case (mode)
      FM_IMMED: begin
        if (len == '0) nxt = sel;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else if (sel != out_q) begin
          nxt   = sel;
          cnt_d = len - 1'b1;
        end
      end
      FM_AFTER: begin
        if (sel != out_q) begin
          if ({1'b0, cnt_q} + 1'b1 >= {1'b0, len}) nxt = sel;
          else cnt_d = cnt_q + 1'b1;
        end
      end
      FM_LOW:  nxt = 1'b0;
      FM_HIGH: nxt = 1'b1;
      default: nxt = sel;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      out_q <= nxt;
      cnt_q <= cnt_d;
    end
  end

  assign rise = nxt & ~out_q;
  assign fall = ~nxt & out_q;

  // R5: lockout window freezes the output
  a_r5_lockout_hold: assert property (@(posedge clk) disable iff (rst)
    (mode == FM_IMMED && cnt_q != '0) |=> $stable(out_q));
  // R6: no change until a full window has been counted
  a_r6_no_early_change: assert property (@(posedge clk) disable iff (rst)
    (mode == FM_AFTER && len > 1 && cnt_q == '0) |=> $stable(out_q));
  // R7: forced levels
  a_r7_forced_low: assert property (@(posedge clk) disable iff (rst)
    (mode == FM_LOW) |=> !out_q);
  a_r7_forced_high: assert property (@(posedge clk) disable iff (rst)
    (mode == FM_HIGH) |=> out_q);
endmodule

// File: rtl/cmpc_regs.sv
module cmpc_regs
  import cmpc_pkg::*;
#(
  parameter  int LEN_W  = 12,
  parameter  int DAC_W  = 8,
  parameter  int ADDR_W = 3,
  localparam int DATA_W = LEN_W + 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rise_evt,
  input  logic              fall_evt,
  output logic [LEN_W-1:0]  flt_len,
  output logic [2:0]        flt_code,
  output logic              stage_en,
  output logic              invert,
  output logic              flt_byp,
  output logic              irq,
  output logic              dma_req
);
  localparam int MODE_LSB  = LEN_W;
  localparam int STAGE_BIT = LEN_W + 3;
  localparam int INV_BIT   = LEN_W + 4;
  localparam int BYP_BIT   = LEN_W + 5;

  logic [DATA_W-1:0] ctrl_q;
  logic [DAC_W-1:0]  level_q;
  logic [1:0]        flags_q, ien_q, den_q, clr;
  logic [DATA_W-1:0] rd_d;
  logic              flag_wr;

  assign flag_wr = wr_en && (wr_addr == ADDR_W'(A_FLAGS));
  assign clr     = flag_wr ? wr_data[1:0] : 2'b00;

  always_comb begin
    case (rd_addr)
      ADDR_W'(A_CTRL):  rd_d = ctrl_q;
      ADDR_W'(A_LEVEL): rd_d = DATA_W'(level_q);
      ADDR_W'(A_FLAGS): rd_d = DATA_W'(flags_q);
      ADDR_W'(A_IRQEN): rd_d = DATA_W'(ien_q);
      ADDR_W'(A_DMAEN): rd_d = DATA_W'(den_q);
      default:          rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      level_q <= '0;
      flags_q <= '0;
      ien_q   <= '0;
      den_q   <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en && wr_addr == ADDR_W'(A_CTRL))  ctrl_q  <= wr_data;
      if (wr_en && wr_addr == ADDR_W'(A_LEVEL)) level_q <= wr_data[DAC_W-1:0];
      if (wr_en && wr_addr == ADDR_W'(A_IRQEN)) ien_q   <= wr_data[1:0];
      if (wr_en && wr_addr == ADDR_W'(A_DMAEN)) den_q   <= wr_data[1:0];
      flags_q <= (flags_q & ~clr) | {fall_evt, rise_evt};
      rd_data <= rd_d;
    end
  end

  assign flt_len  = ctrl_q[LEN_W-1:0];
  assign flt_code = ctrl_q[MODE_LSB +: 3];
  assign stage_en = ctrl_q[STAGE_BIT];
  assign invert   = ctrl_q[INV_BIT];
  assign flt_byp  = ctrl_q[BYP_BIT];
  assign irq      = |(flags_q & ien_q);
  assign dma_req  = |(flags_q & den_q);

  // R9: flags only drop through a write to the flag register
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    !flag_wr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  // R9: hardware set beats a simultaneous clear
  a_r9_rise_wins: assert property (@(posedge clk) disable iff (rst)
    rise_evt |=> flags_q[0]);
  a_r9_fall_wins: assert property (@(posedge clk) disable iff (rst)
    fall_evt |=> flags_q[1]);
endmodule

// File: rtl/cmpc_conditioner.sv
module cmpc_conditioner
  import cmpc_pkg::*;
#(
  parameter  int LEN_W       = 12,
  parameter  int DAC_W       = 8,
  parameter  int ADDR_W      = 3,
  parameter  int SYNC_STAGES = 2,
  localparam int DATA_W      = LEN_W + 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_raw,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              cond_out,
  output logic              irq,
  output logic              dma_req
);
  logic [LEN_W-1:0] flt_len;
  logic [2:0]       flt_code;
  logic             stage_en, invert, flt_byp, sel, rise, fall;
  filt_mode_e       mode;

  assign mode = decode_mode(flt_code, flt_byp);

  cmpc_regs #(.LEN_W(LEN_W), .DAC_W(DAC_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rise_evt(rise), .fall_evt(fall),
    .flt_len(flt_len), .flt_code(flt_code), .stage_en(stage_en),
    .invert(invert), .flt_byp(flt_byp), .irq(irq), .dma_req(dma_req));

  cmpc_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .raw(cmp_raw), .invert(invert),
    .stage_en(stage_en), .sel(sel));

  cmpc_filter #(.LEN_W(LEN_W)) u_filter (
    .clk(clk), .rst(rst), .sel(sel), .mode(mode), .len(flt_len),
    .out_q(cond_out), .rise(rise), .fall(fall));
endmodule

// File: tb/sim_cmpc_conditioner.sv
`timescale 1ns/1ps
module sim_cmpc_conditioner;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmp_raw = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [30:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [30:0] rd_data;
  logic        cond_out, irq, dma_req;

  cmpc_conditioner u0 (
    .clk(clk), .rst(rst), .cmp_raw(cmp_raw), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cond_out(cond_out), .irq(irq), .dma_req(dma_req));

  always #10 clk = ~clk;

  int    vectors = 0;
  int    fails   = 0;
  bit    done    = 0;
  string cur_tag = "R1";

  // behavioural reference state
  bit          rawq[$];
  bit          polq[$];
  bit          m_out;
  int          m_cnt;
  logic [30:0] m_ctrl;
  logic [7:0]  m_lvl;
  logic [1:0]  m_flags, m_ien, m_den;

  task automatic chk(string tag, logic [30:0] act, logic [30:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [30:0] mk(int len, int code, bit stg, bit inv, bit byp);
    return 31'(len) | (31'(code) << 12) | (31'(stg) << 15) | (31'(inv) << 16) | (31'(byp) << 17);
  endfunction

  function automatic logic [30:0] model_read(logic [2:0] a);
    case (a)
      3'd0: return m_ctrl;
      3'd1: return 31'(m_lvl);
      3'd2: return 31'(m_flags);
      3'd3: return 31'(m_ien);
      3'd4: return 31'(m_den);
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      rawq = '{0, 0, 0}; polq = '{0, 0};
      m_out = 0; m_cnt = 0; m_ctrl = '0; m_lvl = '0;
      m_flags = '0; m_ien = '0; m_den = '0;
    end else begin
      bit fin, n;
      int len, code;
      logic [1:0] clr;
      rawq.push_front(cmp_raw); void'(rawq.pop_back());
      polq.push_front(rawq[2] ^ m_ctrl[16]); void'(polq.pop_back());
      fin  = m_ctrl[15] ? polq[1] : polq[0];
      len  = int'(m_ctrl[11:0]);
      code = m_ctrl[17] ? 0 : int'(m_ctrl[14:12]);
      if (code < 4) code = 0;
      n = m_out;
      if (code == 0) begin n = fin; m_cnt = 0; end
      else if (code == 6) begin n = 0; m_cnt = 0; end
      else if (code == 7) begin n = 1; m_cnt = 0; end
      else if (code == 4) begin
        if (len == 0) begin n = fin; m_cnt = 0; end
        else if (m_cnt > 0) m_cnt--;
        else if (fin != m_out) begin n = fin; m_cnt = len - 1; end
      end else begin
        if (fin == m_out) m_cnt = 0;
        else if (m_cnt + 1 >= len) begin n = fin; m_cnt = 0; end
        else m_cnt++;
      end
      clr = (wr_en && wr_addr == 3'd2) ? wr_data[1:0] : 2'b00;
      m_flags = (m_flags & ~clr) | {(!n && m_out), (n && !m_out)};
      m_out = n;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_ctrl = wr_data;
          3'd1: m_lvl  = wr_data[7:0];
          3'd3: m_ien  = wr_data[1:0];
          3'd4: m_den  = wr_data[1:0];
          default: ;
        endcase
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({cur_tag, " cond_out"}, 31'(cond_out), 31'(m_out));
      chk("R10 irq", 31'(irq), 31'(|(m_flags & m_ien)));
      chk("R10 dma_req", 31'(dma_req), 31'(|(m_flags & m_den)));
    end
  end

  task automatic wr(logic [2:0] a, logic [30:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R12: data due one edge after the address
  task automatic rd(logic [2:0] a, string tag);
    logic [30:0] e;
    rd_addr = a; e = model_read(a);
    @(negedge clk);
    chk({tag, " R12 read"}, rd_data, e);
  endtask

  task automatic waitn(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic settle(bit lvl, int n);
    cmp_raw = lvl; waitn(n);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    waitn(3);
    rst = 1'b0;
    // R1: reset state
    chk("R1 cond_out", 31'(cond_out), 0);
    chk("R1 irq", 31'(irq), 0);
    chk("R1 dma_req", 31'(dma_req), 0);
    for (int a = 0; a < 5; a++) begin
      rd_addr = 3'(a); @(negedge clk);
      chk("R1 register", rd_data, 0);
    end

    // R2: latency without and with extra stage
    cur_tag = "R2";
    settle(0, 5);
    cmp_raw = 1; waitn(2);
    chk("R2 not yet", 31'(cond_out), 0);
    waitn(1);
    chk("R2 three edges", 31'(cond_out), 1);
    settle(0, 6);
    wr(0, mk(0, 0, 1, 0, 0)); settle(0, 4);
    cmp_raw = 1; waitn(3);
    chk("R2 stage not yet", 31'(cond_out), 0);
    waitn(1);
    chk("R2 four edges", 31'(cond_out), 1);
    settle(0, 6);

    // R3: inversion
    cur_tag = "R3";
    wr(0, mk(0, 0, 0, 1, 0)); waitn(4);
    chk("R3 inverted low", 31'(cond_out), 1);
    settle(1, 5);
    chk("R3 inverted high", 31'(cond_out), 0);
    settle(0, 5);
    wr(0, mk(0, 0, 0, 0, 0)); waitn(4);
    chk("R3 plain", 31'(cond_out), 0);

    // R4: reserved code and bypass bit pass a one-cycle pulse
    cur_tag = "R4";
    wr(0, mk(5, 2, 0, 0, 0)); settle(0, 4);
    cmp_raw = 1; waitn(1); cmp_raw = 0; waitn(2);
    chk("R4 reserved code pulse", 31'(cond_out), 1);
    waitn(1);
    chk("R4 reserved code pulse end", 31'(cond_out), 0);
    wr(0, mk(5, 5, 0, 0, 1)); settle(0, 4);
    cmp_raw = 1; waitn(1); cmp_raw = 0; waitn(2);
    chk("R4 bypass bit pulse", 31'(cond_out), 1);
    settle(0, 5);

    // R5: change immediately, window 4
    cur_tag = "R5";
    wr(0, mk(4, 4, 0, 0, 0)); settle(0, 6);
    cmp_raw = 1; waitn(1); cmp_raw = 0; waitn(2);
    chk("R5 immediate take", 31'(cond_out), 1);
    waitn(3);
    chk("R5 lockout holds", 31'(cond_out), 1);
    waitn(1);
    chk("R5 release", 31'(cond_out), 0);
    settle(0, 8);

    // R6: change after filter, window 4
    cur_tag = "R6";
    wr(0, mk(4, 5, 0, 0, 0)); settle(0, 6);
    cmp_raw = 1; waitn(3); cmp_raw = 0; waitn(8);
    chk("R6 short pulse rejected", 31'(cond_out), 0);
    cmp_raw = 1; waitn(5);
    chk("R6 not before window", 31'(cond_out), 0);
    cmp_raw = 0; waitn(1);
    chk("R6 after full window", 31'(cond_out), 1);
    settle(0, 10);

    // R7: forced levels
    cur_tag = "R7";
    wr(0, mk(3, 6, 0, 0, 0));
    for (int i = 0; i < 10; i++) begin cmp_raw = ~cmp_raw; @(negedge clk); end
    chk("R7 forced low", 31'(cond_out), 0);
    wr(0, mk(3, 7, 0, 0, 0));
    for (int i = 0; i < 10; i++) begin cmp_raw = ~cmp_raw; @(negedge clk); end
    chk("R7 forced high", 31'(cond_out), 1);
    wr(0, mk(0, 0, 0, 0, 0)); settle(0, 5);

    // R8: zero window acts as pass-through
    cur_tag = "R8";
    wr(0, mk(0, 5, 0, 0, 0)); settle(0, 4);
    cmp_raw = 1; waitn(1); cmp_raw = 0; waitn(2);
    chk("R8 after-filter zero window", 31'(cond_out), 1);
    wr(0, mk(0, 4, 0, 0, 0)); settle(0, 4);
    cmp_raw = 1; waitn(1); cmp_raw = 0; waitn(2);
    chk("R8 immediate zero window", 31'(cond_out), 1);
    settle(0, 4);

    // R9: flags, write-1-to-clear, set priority
    cur_tag = "R9";
    wr(0, mk(0, 0, 0, 0, 0));
    wr(2, 3); waitn(2);
    rd(2, "R9 cleared");
    chk("R9 flags zero", rd_data, 0);
    settle(1, 5);
    rd(2, "R9 rise flag");
    chk("R9 rise bit0", rd_data, 1);
    wr(2, 1); rd(2, "R9 w1c");
    chk("R9 bit0 cleared", rd_data, 0);
    settle(0, 5);
    rd(2, "R9 fall flag");
    chk("R9 fall bit1", rd_data, 2);
    cmp_raw = 1; waitn(2); wr(2, 1); waitn(1);
    rd(2, "R9 set wins");
    chk("R9 set beats clear", rd_data[0], 1);
    wr(2, 3); settle(1, 3);

    // R10: request routing
    cur_tag = "R10";
    wr(3, 1); wr(2, 3); waitn(1);
    chk("R10 irq idle", 31'(irq), 0);
    settle(0, 4);
    chk("R10 fall not routed", 31'(irq), 0);
    wr(3, 2); waitn(1);
    chk("R10 fall routed irq", 31'(irq), 1);
    chk("R10 dma off", 31'(dma_req), 0);
    wr(4, 2); waitn(1);
    chk("R10 fall routed dma", 31'(dma_req), 1);
    wr(2, 3); waitn(1);
    chk("R10 cleared", 31'(irq | dma_req), 0);

    // R11: stored-only fields
    cur_tag = "R11";
    wr(0, 31'h7ffc_0000); wr(1, 31'h1a5); wr(7, 31'h1234);
    rd(0, "R11 ctrl");
    chk("R11 ctrl readback", rd_data, 31'h7ffc_0000);
    rd(1, "R11 level");
    chk("R11 level readback", rd_data, 31'h0a5);
    rd(7, "R11 unmapped");
    chk("R11 unmapped zero", rd_data, 0);
    settle(1, 5);
    chk("R11 pass unaffected", 31'(cond_out), 1);
    settle(0, 5);
    chk("R11 pass unaffected low", 31'(cond_out), 0);

    // mixed random stretches checked every cycle against the model
    cur_tag = "R5 R6 random";
    for (int c = 0; c < 8; c++) begin
      wr(0, mk(int'($urandom_range(0, 6)), int'($urandom_range(0, 7)),
               1'($urandom), 1'($urandom), 1'($urandom_range(0, 5) == 0)));
      wr(3, 2'($urandom)); wr(4, 2'($urandom));
      for (int i = 0; i < 200; i++) begin
        if ($urandom_range(0, 3) == 0) cmp_raw = ~cmp_raw;
        if ($urandom_range(0, 15) == 0) wr(2, 2'($urandom));
        else @(negedge clk);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule